// File: doc/BRIEF.md
# Cacheable Address Region Decoder

This block decides, for each physical memory address presented to it, whether the access may be held in the external cache. The answer depends on a set of configuration inputs: the amount of DRAM installed, the cache size, the tag-width mode, two programmable noncacheable holes, and two enables that let the video and system firmware areas in the legacy upper-memory window be cached. The result is registered, so the flag is available one clock after the address and can steer the next bus cycle.

The cacheable ceiling is the smaller of two values: the installed DRAM size, and the cache size scaled by a factor that depends on the tag width. No separate region setup is needed for this ceiling. Below it, the two holes and the legacy window remove further addresses. Addresses below the ceiling that no exclusion touches are cacheable.

Top module: `cache_region_decoder`

## Requirements
- R1: While `rst_i` is high, `cacheable_o` is 0 at every clock edge.
- R2: `cacheable_o` shows the decision for the inputs sampled at the previous rising edge of `clk_i`. Each cycle gives a new decision.
- R3: An address at or above `dram_mb_i` × 1 MiB is noncacheable.
- R4: When `tag_mode_i` is 0, an address at or above `cache_kb_i` × 1 KiB × 256 is noncacheable.
- R5: When `tag_mode_i` is 1 the cache multiplier is 512. When it is 2 or 3 the multiplier is 1024.
- R6: Window n hits when `win_en_i[n]` is 1 and the address matches `win_base_i[n]` in every bit at and above bit 12 + `win_sz_i[n]` (window size 4 KiB << `win_sz_i[n]`). A hit makes the address noncacheable and overrides both shadow enables.
- R7: A window whose enable bit is 0 has no effect on the result.
- R8: The legacy areas 0xA0000–0xBFFFF and 0xC8000–0xEFFFF are always noncacheable.
- R9: The video firmware area 0xC0000–0xC7FFF is cacheable only when `vid_shadow_i` is 1.
- R10: The system firmware area 0xF0000–0xFFFFF is cacheable only when `sys_shadow_i` is 1.
- R11: Any other address below both the DRAM limit and the cache limit is cacheable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous reset, active high |
| addr_i | input | ADDR_W | Physical address to classify |
| dram_mb_i | input | DRAM_W | Installed DRAM size in MiB |
| cache_kb_i | input | CACHE_W | Cache size in KiB |
| tag_mode_i | input | 2 | Tag width: 0 = x256, 1 = x512, 2/3 = x1024 |
| win_en_i | input | NWIN | Enable bit for each hole |
| win_base_i | input | NWIN x ADDR_W | Base address of each hole |
| win_sz_i | input | NWIN x SZ_W | Size code of each hole, size = 4 KiB << code |
| vid_shadow_i | input | 1 | Makes the video firmware area cacheable |
| sys_shadow_i | input | 1 | Makes the system firmware area cacheable |
| cacheable_o | output | 1 | Registered cacheable flag |

## Verification
Two situations are the hardest to reach: an address sitting exactly at the cache-derived ceiling while DRAM is the larger size, and a hole that covers a firmware area whose shadow enable is set. Uniform random addresses almost never reach either one. The stimulus therefore draws hole bases from inside installed DRAM and places many addresses at offsets close to the hole edges and both limits. Directed steps then fix the ceiling boundaries under each tag mode, and a hole covering the first megabyte with both shadows on.

// File: rtl/crd_pkg.sv
package crd_pkg;
   // legacy window in 32 KiB blocks (address bits [19:15])
   localparam int unsigned LEG_BLK_LG   = 15;
   localparam int unsigned LEG_FIRST    = 20;  // 0xA0000
   localparam int unsigned LEG_VID_BLK  = 24;  // 0xC0000..0xC7FFF
   localparam int unsigned LEG_SYS_BLK0 = 30;  // 0xF0000..0xFFFFF
   localparam int unsigned MIB_LG       = 20;
   localparam int unsigned KIB_LG       = 10;
   localparam int unsigned BASE_MULT_LG = 8;   // x256
   localparam int unsigned WIN_LG_MIN   = 12;  // smallest hole 4 KiB

   function automatic int crd_max3(input int a, input int b, input int c);
      int m;
      m = (a > b) ? a : b;
      return (m > c) ? m : c;
   endfunction
endpackage

// File: rtl/crd_limit.sv
module crd_limit
   import crd_pkg::*;
#(
   parameter int ADDR_W  = 32,
   parameter int DRAM_W  = 12,
   parameter int CACHE_W = 11
) (
   input  logic [ADDR_W-1:0]  addr_i,
   input  logic [DRAM_W-1:0]  dram_mb_i,
   input  logic [CACHE_W-1:0] cache_kb_i,
   input  logic [1:0]         tag_mode_i,
   output logic               in_limit_o
);
   localparam int LIM_W = crd_max3(ADDR_W, DRAM_W + MIB_LG,
                                   CACHE_W + KIB_LG + BASE_MULT_LG + 2) + 1;

   logic [LIM_W-1:0] dram_lim;
   logic [LIM_W-1:0] cache_lim;
   logic [LIM_W-1:0] eff_lim;
   logic [1:0]       mult_sh;

   always_comb begin
      unique case (tag_mode_i)
         2'd0:    mult_sh = 2'd0;
         2'd1:    mult_sh = 2'd1;
         default: mult_sh = 2'd2;
      endcase
      dram_lim   = LIM_W'(dram_mb_i) << MIB_LG;
      cache_lim  = LIM_W'(cache_kb_i) << (KIB_LG + BASE_MULT_LG + 32'(mult_sh));
      eff_lim    = (dram_lim < cache_lim) ? dram_lim : cache_lim;
      in_limit_o = LIM_W'(addr_i) < eff_lim;
   end
endmodule

// File: rtl/crd_window.sv
module crd_window
   import crd_pkg::*;
#(
   parameter int ADDR_W = 32,
   parameter int SZ_W   = 4
) (
   input  logic [ADDR_W-1:0] addr_i,
   input  logic              en_i,
   input  logic [ADDR_W-1:0] base_i,
   input  logic [SZ_W-1:0]   sz_i,
   output logic              hit_o
);
   logic [ADDR_W-1:0] keep;

   always_comb begin
      keep  = {ADDR_W{1'b1}} << (WIN_LG_MIN + 32'(sz_i));
      hit_o = en_i && (((addr_i ^ base_i) & keep) == '0);
   end
endmodule

// File: rtl/crd_legacy.sv
module crd_legacy
   import crd_pkg::*;
#(
   parameter int ADDR_W = 32
) (
   input  logic [ADDR_W-1:0] addr_i,
   input  logic              vid_shadow_i,
   input  logic              sys_shadow_i,
   output logic              legacy_nc_o
);
   logic       below_1m;
   logic [4:0] blk;
   logic       in_upper, is_vid, is_sys;

   always_comb begin
      below_1m    = (addr_i[ADDR_W-1:MIB_LG] == '0);
      blk         = addr_i[MIB_LG-1:LEG_BLK_LG];
      in_upper    = below_1m && (32'(blk) >= LEG_FIRST);
      is_vid      = in_upper && (32'(blk) == LEG_VID_BLK);
      is_sys      = in_upper && (32'(blk) >= LEG_SYS_BLK0);
      legacy_nc_o = in_upper && !(is_vid && vid_shadow_i)
                             && !(is_sys && sys_shadow_i);
   end
endmodule

// File: rtl/cache_region_decoder.sv
module cache_region_decoder
   import crd_pkg::*;
#(
   parameter int ADDR_W  = 32,
   parameter int DRAM_W  = 12,
   parameter int CACHE_W = 11,
   parameter int NWIN    = 2,
   parameter int SZ_W    = 4
) (
   input  logic                        clk_i,
   input  logic                        rst_i,
   input  logic [ADDR_W-1:0]           addr_i,
   input  logic [DRAM_W-1:0]           dram_mb_i,
   input  logic [CACHE_W-1:0]          cache_kb_i,
   input  logic [1:0]                  tag_mode_i,
   input  logic [NWIN-1:0]             win_en_i,
   input  logic [NWIN-1:0][ADDR_W-1:0] win_base_i,
   input  logic [NWIN-1:0][SZ_W-1:0]   win_sz_i,
   input  logic                        vid_shadow_i,
   input  logic                        sys_shadow_i,
   output logic                        cacheable_o
);
   if (ADDR_W < 21) begin : g_bad_addr
      $error("ADDR_W must cover the first megabyte");
   end
   if (WIN_LG_MIN + (1 << SZ_W) - 1 > ADDR_W) begin : g_bad_sz
      $error("largest hole exceeds the address space");
   end
   if (NWIN < 1) begin : g_bad_nwin
      $error("NWIN must be at least 1");
   end

   logic            in_limit;
   logic            legacy_nc;
   logic [NWIN-1:0] win_hit;
   logic            cacheable_d;

   crd_limit #(.ADDR_W(ADDR_W), .DRAM_W(DRAM_W), .CACHE_W(CACHE_W)) i_limit (
      .addr_i     (addr_i),
      .dram_mb_i  (dram_mb_i),
      .cache_kb_i (cache_kb_i),
      .tag_mode_i (tag_mode_i),
      .in_limit_o (in_limit)
   );

   for (genvar w = 0; w < NWIN; w++) begin : g_win
      crd_window #(.ADDR_W(ADDR_W), .SZ_W(SZ_W)) i_win (
         .addr_i (addr_i),
         .en_i   (win_en_i[w]),
         .base_i (win_base_i[w]),
         .sz_i   (win_sz_i[w]),
         .hit_o  (win_hit[w])
      );
   end

   crd_legacy #(.ADDR_W(ADDR_W)) i_legacy (
      .addr_i       (addr_i),
      .vid_shadow_i (vid_shadow_i),
      .sys_shadow_i (sys_shadow_i),
      .legacy_nc_o  (legacy_nc)
   );

   // priority: limit, then holes, then legacy window
   always_comb begin
      if (!in_limit)        cacheable_d = 1'b0;
      else if (|win_hit)    cacheable_d = 1'b0;
      else if (legacy_nc)   cacheable_d = 1'b0;
      else                  cacheable_d = 1'b1;
   end

   always_ff @(posedge clk_i) begin
      if (rst_i) cacheable_o <= 1'b0;
      else       cacheable_o <= cacheable_d;
   end
endmodule

// File: rtl/crd_checker.sv
module crd_checker
   import crd_pkg::*;
#(
   parameter int ADDR_W  = 32,
   parameter int DRAM_W  = 12,
   parameter int CACHE_W = 11,
   parameter int NWIN    = 2,
   parameter int SZ_W    = 4
) (
   input logic                        clk_i,
   input logic                        rst_i,
   input logic [ADDR_W-1:0]           addr_i,
   input logic [DRAM_W-1:0]           dram_mb_i,
   input logic [CACHE_W-1:0]          cache_kb_i,
   input logic [1:0]                  tag_mode_i,
   input logic [NWIN-1:0]             win_en_i,
   input logic [NWIN-1:0][ADDR_W-1:0] win_base_i,
   input logic [NWIN-1:0][SZ_W-1:0]   win_sz_i,
   input logic                        vid_shadow_i,
   input logic                        sys_shadow_i,
   input logic                        cacheable_o
);
   localparam int CW = crd_max3(ADDR_W, DRAM_W + MIB_LG, 8) + 1;

   logic above_dram, in_hole_a, in_hole_b, vid_area;
   assign above_dram = CW'(addr_i) >= (CW'(dram_mb_i) * (CW'(1) << MIB_LG));
   assign in_hole_a  = (32'(addr_i) >= 32'h000A_0000) && (32'(addr_i) <= 32'h000B_FFFF);
   assign in_hole_b  = (32'(addr_i) >= 32'h000C_8000) && (32'(addr_i) <= 32'h000E_FFFF);
   assign vid_area   = (32'(addr_i) >= 32'h000C_0000) && (32'(addr_i) <= 32'h000C_7FFF);

   a_r1_reset_low: assert property (@(posedge clk_i) rst_i |=> !cacheable_o);

   a_r3_above_dram: assert property (@(posedge clk_i) disable iff (rst_i)
      above_dram |=> !cacheable_o);

   a_r8_legacy_hole: assert property (@(posedge clk_i) disable iff (rst_i)
      (in_hole_a || in_hole_b) |=> !cacheable_o);

   a_r9_video_off: assert property (@(posedge clk_i) disable iff (rst_i)
      (vid_area && !vid_shadow_i) |=> !cacheable_o);

   for (genvar w = 0; w < NWIN; w++) begin : g_chk
      logic hole;
      assign hole = win_en_i[w] &&
         ((addr_i >> (WIN_LG_MIN + 32'(win_sz_i[w]))) ==
          (win_base_i[w] >> (WIN_LG_MIN + 32'(win_sz_i[w]))));
      a_r6_window_hole: assert property (@(posedge clk_i) disable iff (rst_i)
         hole |=> !cacheable_o);
   end
endmodule

bind cache_region_decoder crd_checker #(
   .ADDR_W(ADDR_W), .DRAM_W(DRAM_W), .CACHE_W(CACHE_W), .NWIN(NWIN), .SZ_W(SZ_W)
) i_crd_checker (.*);

// File: tb/test_cache_region_decoder.sv
module test_cache_region_decoder;
   localparam int ADDR_W = 32, DRAM_W = 12, CACHE_W = 11, NWIN = 2, SZ_W = 4;

   logic                        clk = 1'b0;
   logic                        rst;
   logic [ADDR_W-1:0]           addr;
   logic [DRAM_W-1:0]           dram_mb;
   logic [CACHE_W-1:0]          cache_kb;
   logic [1:0]                  tag_mode;
   logic [NWIN-1:0]             win_en;
   logic [NWIN-1:0][ADDR_W-1:0] win_base;
   logic [NWIN-1:0][SZ_W-1:0]   win_sz;
   logic                        vid_sh, sys_sh;
   logic                        cacheable;

   int total = 0;
   int bad   = 0;

   always #2ns clk = ~clk;

   cache_region_decoder #(.ADDR_W(ADDR_W), .DRAM_W(DRAM_W), .CACHE_W(CACHE_W),
                          .NWIN(NWIN), .SZ_W(SZ_W)) i_cache_region_decoder (
      .clk_i(clk), .rst_i(rst), .addr_i(addr), .dram_mb_i(dram_mb),
      .cache_kb_i(cache_kb), .tag_mode_i(tag_mode), .win_en_i(win_en),
      .win_base_i(win_base), .win_sz_i(win_sz), .vid_shadow_i(vid_sh),
      .sys_shadow_i(sys_sh), .cacheable_o(cacheable)
   );

   // reference: returns the number of the requirement that decides
   function automatic int ref_rule();
      longint a, lim_d, lim_c, sz;
      int sh;
      a     = longint'(addr);
      lim_d = longint'(dram_mb) * 64'd1048576;
      sh    = (tag_mode == 2'd0) ? 8 : (tag_mode == 2'd1) ? 9 : 10;
      lim_c = longint'(cache_kb) * 64'd1024 * (64'd1 << sh);
      if (a >= lim_d) return 3;
      if (a >= lim_c) return (tag_mode == 2'd0) ? 4 : 5;
      for (int w = 0; w < NWIN; w++) begin
         sz = 64'd4096 << win_sz[w];
         if (win_en[w] && (a / sz) == (longint'(win_base[w]) / sz)) return 6;
      end
      if (a >= 64'hA0000 && a <= 64'hFFFFF) begin
         if (a >= 64'hC0000 && a <= 64'hC7FFF) return vid_sh ? 11 : 9;
         if (a >= 64'hF0000) return sys_sh ? 11 : 10;
         return 8;
      end
      return 11;
   endfunction

   task automatic chk(input logic exp, input string tag);
      total++;
      if (cacheable !== exp) begin
         bad++;
         $display("FAIL %s addr=%h actual=%b expected=%b", tag, addr, cacheable, exp);
      end
   endtask

   // called at a falling edge: inputs are set, result checked one cycle later
   task automatic step(input logic exp, input string tag);
      @(negedge clk);
      chk(exp, tag);
   endtask

   task automatic step_ref();
      int r;
      r = ref_rule();
      step(r == 11, $sformatf("R%0d/R2", r));
   endtask

   initial begin
      int unsigned sd;
      sd = $urandom(32'h5eed_c0de);
      rst = 1'b1; addr = '0; dram_mb = 12'd128; cache_kb = 11'd256; tag_mode = 2'd0;
      win_en = '0; win_base = '0; win_sz = '0; vid_sh = 1'b0; sys_sh = 1'b0;
      addr = 32'h1000;  // would be cacheable, reset must hold it low
      repeat (3) @(negedge clk);
      chk(1'b0, "R1");
      rst = 1'b0;

      // limits: dram 128 MiB, cache 256 KiB x256 = 64 MiB
      step(1'b1, "R11");                     // 0x1000 from above
      addr = 32'h03FF_FFFF; step(1'b1, "R4");
      addr = 32'h0400_0000; step(1'b0, "R4");
      addr = 32'h0000_2000; step(1'b1, "R2");   // back-to-back change
      tag_mode = 2'd1; addr = 32'h0400_0000; step(1'b1, "R5");
      addr = 32'h0800_0000; step(1'b0, "R3");
      dram_mb = 12'd512; tag_mode = 2'd2;
      addr = 32'h0FFF_FFFF; step(1'b1, "R5");
      addr = 32'h1000_0000; step(1'b0, "R5");
      tag_mode = 2'd3; addr = 32'h0FFF_FFFF; step(1'b1, "R5");
      dram_mb = 12'd100; addr = 32'h0640_0000; step(1'b0, "R3");
      addr = 32'h063F_FFFF; step(1'b1, "R3");

      // holes
      win_en = 2'b01; win_base[0] = 32'h0010_0000; win_sz[0] = 4'd8;
      addr = 32'h0018_0000; step(1'b0, "R6");
      addr = 32'h0020_0000; step(1'b1, "R6");
      win_en = 2'b00; addr = 32'h0018_0000; step(1'b1, "R7");
      win_en = 2'b10; win_base[1] = 32'h0000_0000; win_sz[1] = 4'd8;
      vid_sh = 1'b1; sys_sh = 1'b1;
      addr = 32'h000C_0000; step(1'b0, "R6");
      addr = 32'h000F_0000; step(1'b0, "R6");
      win_en = 2'b00;

      // legacy window, both shadows on
      addr = 32'h000A_0000; step(1'b0, "R8");
      addr = 32'h000B_FFFF; step(1'b0, "R8");
      addr = 32'h000C_8000; step(1'b0, "R8");
      addr = 32'h000E_FFFF; step(1'b0, "R8");
      addr = 32'h0009_FFFF; step(1'b1, "R11");
      addr = 32'h000C_0000; step(1'b1, "R9");
      addr = 32'h000C_7FFF; step(1'b1, "R9");
      vid_sh = 1'b0; addr = 32'h000C_0000; step(1'b0, "R9");
      addr = 32'h000F_0000; step(1'b1, "R10");
      sys_sh = 1'b0; addr = 32'h000F_FFFF; step(1'b0, "R10");
      addr = 32'h0010_0000; step(1'b1, "R11");

      // constrained random
      for (int c = 0; c < 300; c++) begin
         longint lim;
         dram_mb  = DRAM_W'($urandom_range(0, 4095));
         cache_kb = CACHE_W'($urandom_range(0, 2047));
         tag_mode = 2'($urandom);
         vid_sh   = 1'($urandom); sys_sh = 1'($urandom);
         win_en   = NWIN'($urandom);
         lim = longint'(dram_mb) * 64'd1048576 + 1;
         for (int w = 0; w < NWIN; w++) begin
            win_sz[w]   = SZ_W'($urandom);
            win_base[w] = ADDR_W'(longint'($urandom) % lim);
         end
         for (int k = 0; k < 20; k++) begin
            int unsigned pick;
            pick = $urandom_range(0, 4);
            case (pick)
               0: addr = ADDR_W'($urandom_range(0, 32'hFFFFF));
               1: addr = win_base[k % NWIN] + ADDR_W'($urandom_range(0, 32'h2000))
                         - ADDR_W'($urandom_range(0, 32'h1000));
               2: addr = ADDR_W'(longint'(dram_mb) * 64'd1048576) - ADDR_W'($urandom_range(0, 2));
               3: addr = ADDR_W'(longint'(cache_kb) * 64'd1024 <<
                         ((tag_mode == 0) ? 8 : (tag_mode == 1) ? 9 : 10))
                         - ADDR_W'($urandom_range(0, 2));
               default: addr = ADDR_W'($urandom);
            endcase
            step_ref();
         end
      end

      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule